// File: doc/BRIEF.md
# Qualified Zero-Crossing Pulse Generator

This block watches the digital output of an external demagnetization comparator attached to the auxiliary winding of a boost inductor. A low comparator level means the winding voltage has dropped below zero, which happens just before a valley of the switch drain-source voltage. The block emits a one-clock "below zero" event that the switching controller uses to start its next period.

A falling edge only produces an event if the comparator level was high without any break for a programmable number of clock cycles before it fell. Shorter highs, and the falling edges that end them, are treated as ringing or noise and dropped. The comparator level first passes through a synchronizer. No events are produced while the gate drive is on or while the block is disabled. Because the switching period varies, the controller may skip valleys, so every later qualified valley also yields an event. A saturating counter reports how many qualified valleys have occurred since the gate last turned on.

Top module: `zc_qual_pulse`

## Requirements
- R1: After reset, `below_pulse` is 0 and `valley_cnt` is 0.
- R2: When `cmp_in` has been sampled high on at least `QUAL_CYC` consecutive rising edges and then goes low, `below_pulse` is 1 during the clock cycle after the third rising edge that samples `cmp_in` low. This assumes `en` is 1 and `gate_on` is 0.
- R3: A high interval of fewer than `QUAL_CYC` sampled cycles, followed by a fall, produces no pulse. `QUAL_CYC-1` is the boundary case.
- R4: Each `below_pulse` event is exactly one clock wide. A long low period after a qualified fall gives only one pulse.
- R5: While `gate_on` is 1, the high-time count is held at zero and no pulse is issued, including for a fall that arrives in the same cycle that the gate turns on. After the gate turns off, the high time must qualify again from zero.
- R6: While `en` is 0, no pulse is issued and qualification is cleared. Once `en` returns to 1, a qualified fall produces a pulse again.
- R7: Every qualified fall produces its own pulse, so back-to-back valleys give back-to-back events.
- R8: `valley_cnt` increases by one after each pulse and saturates at 2^`VCNT_W`-1.
- R9: `valley_cnt` reads 0 in the cycle after `gate_on` is sampled high.
- R10: A single low sample inside a high interval restarts qualification. Two high runs that are each shorter than `QUAL_CYC` give no pulse, even when their combined length exceeds `QUAL_CYC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_in | input | 1 | Asynchronous comparator level, low = below zero |
| gate_on | input | 1 | Gate drive currently on |
| en | input | 1 | Detection enable |
| below_pulse | output | 1 | One-cycle qualified below-zero event |
| valley_cnt | output | VCNT_W | Saturating count of qualified valleys since the gate last turned on |

## Verification
On every cycle, the checker confirms four things: a pulse never lasts two cycles, no pulse follows a cycle with the gate on or detection disabled, every pulse was preceded by a low comparator level at the right depth, and the valley counter either steps by one or clears on gate-on. Only the bench scenarios can show the qualification boundary, because it depends on a long history of inputs. These scenarios cover exactly `QUAL_CYC` against `QUAL_CYC-1` high cycles, the restart after a one-cycle dropout, the requalification after the gate turns off, and saturation of the counter after many valleys.

// File: rtl/zcq_pkg.sv
package zcq_pkg;
  typedef enum logic {
    QS_COUNT = 1'b0,
    QS_ARMED = 1'b1
  } qual_state_e;
endpackage

// File: rtl/zcq_sync.sv
module zcq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d_async;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/zcq_qualifier.sv
module zcq_qualifier
  import zcq_pkg::*;
#(
  parameter int QUAL_CYC = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic block,
  output logic evt
);
  localparam int CW = (QUAL_CYC < 2) ? 1 : $clog2(QUAL_CYC);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYC - 1);

  qual_state_e     st;
  logic [CW-1:0]   hcnt;

  always_ff @(posedge clk) begin
    if (rst || block) begin
      st   <= QS_COUNT;
      hcnt <= '0;
      evt  <= 1'b0;
    end else if (lvl) begin
      evt <= 1'b0;
      if (st == QS_COUNT) begin
        if (hcnt == LAST) begin
          st   <= QS_ARMED;
          hcnt <= '0;
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end else begin
      evt  <= (st == QS_ARMED);
      st   <= QS_COUNT;
      hcnt <= '0;
    end
  end
endmodule

// File: rtl/zcq_valley_cnt.sv
module zcq_valley_cnt #(
  parameter int VCNT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              inc,
  output logic [VCNT_W-1:0] cnt
);
  localparam logic [VCNT_W-1:0] TOP = {VCNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr)              cnt <= '0;
    else if (inc && cnt != TOP)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/zc_qual_pulse.sv
module zc_qual_pulse #(
  parameter int QUAL_CYC    = 20,
  parameter int SYNC_STAGES = 2,
  parameter int VCNT_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_in,
  input  logic              gate_on,
  input  logic              en,
  output logic              below_pulse,
  output logic [VCNT_W-1:0] valley_cnt
);
  logic lvl_s;
  logic hold_off;

  assign hold_off = gate_on | ~en;

  zcq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (cmp_in),
    .q_sync  (lvl_s)
  );

  zcq_qualifier #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk   (clk),
    .rst   (rst),
    .lvl   (lvl_s),
    .block (hold_off),
    .evt   (below_pulse)
  );

  zcq_valley_cnt #(.VCNT_W(VCNT_W)) u_vcnt (
    .clk (clk),
    .rst (rst),
    .clr (gate_on),
    .inc (below_pulse),
    .cnt (valley_cnt)
  );
endmodule

// File: rtl/zcq_checker.sv
module zcq_checker #(
  parameter int VCNT_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cmp_in,
  input logic              gate_on,
  input logic              en,
  input logic              below_pulse,
  input logic [VCNT_W-1:0] valley_cnt
);
  localparam logic [VCNT_W-1:0] TOP = {VCNT_W{1'b1}};

  // R4
  pulse_one_wide_chk: assert property (@(posedge clk) disable iff (rst)
    below_pulse |=> !below_pulse);

  // R5
  gate_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    gate_on |=> !below_pulse);

  // R6
  en_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !below_pulse);

  // R2
  fall_seen_chk: assert property (@(posedge clk) disable iff (rst)
    below_pulse |-> !$past(cmp_in, 3));

  // R9
  vcnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    gate_on |=> valley_cnt == '0);

  // R8
  vcnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (below_pulse && !gate_on && valley_cnt != TOP) |=> valley_cnt == $past(valley_cnt) + 1'b1);
endmodule

bind zc_qual_pulse zcq_checker #(.VCNT_W(VCNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmp_in      (cmp_in),
  .gate_on     (gate_on),
  .en          (en),
  .below_pulse (below_pulse),
  .valley_cnt  (valley_cnt)
);

// File: tb/zc_qual_pulse_tb.sv
`timescale 1ns/1ps
module zc_qual_pulse_tb;
  localparam int QUAL   = 20;
  localparam int VW     = 4;
  localparam int VMAX   = (1 << VW) - 1;
  localparam int NV     = 8;
  // {high cycles, low cycles, expected pulses}
  localparam int VEC [NV][3] = '{
    '{20, 6, 1}, '{19, 6, 0}, '{1, 6, 0},  '{40, 6, 1},
    '{10, 1, 0}, '{10, 6, 0}, '{21, 6, 1}, '{5, 6, 0}
  };

  logic clk = 1'b0;
  logic rst, cmp_in, gate_on, en;
  logic below_pulse;
  logic [VW-1:0] valley_cnt;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  zc_qual_pulse #(.QUAL_CYC(QUAL), .SYNC_STAGES(2), .VCNT_W(VW)) u_dut (
    .clk(clk), .rst(rst), .cmp_in(cmp_in), .gate_on(gate_on), .en(en),
    .below_pulse(below_pulse), .valley_cnt(valley_cnt)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive high for hi cycles then low for lo cycles; count pulses and widest run.
  task automatic burst(input int hi, input int lo, output int npulse, output int maxw);
    int run;
    npulse = 0; maxw = 0; run = 0;
    for (int i = 0; i < hi + lo; i++) begin
      @(negedge clk);
      if (i > 0) begin
        if (below_pulse) begin
          run++;
          if (run == 1) npulse++;
          if (run > maxw) maxw = run;
        end else run = 0;
      end
      cmp_in = (i < hi);
    end
    @(negedge clk);
    if (below_pulse) begin
      run++;
      if (run == 1) npulse++;
      if (run > maxw) maxw = run;
    end
  endtask

  initial begin
    #(4 * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int np, mw, sum, lat;
    rst = 1'b1; cmp_in = 1'b0; gate_on = 1'b0; en = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset values
    check(below_pulse == 1'b0, "R1 pulse", below_pulse, 0);
    check(valley_cnt == 0, "R1 vcnt", valley_cnt, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // Table: R2 R3 R4 R7 R10 boundary and glitch patterns
    sum = 0;
    for (int v = 0; v < NV; v++) begin
      burst(VEC[v][0], VEC[v][1], np, mw);
      check(np == VEC[v][2], "R2/R3/R10 pulses per burst", np, VEC[v][2]);
      check(mw <= 1, "R4 pulse width", mw, 1);
      sum += VEC[v][2];
    end
    check(int'(valley_cnt) == sum, "R7 R8 valley count", valley_cnt, sum);

    // R2 latency: pulse in cycle after third edge that samples low
    for (int i = 0; i < 25; i++) begin @(negedge clk); cmp_in = 1'b1; end
    @(negedge clk); cmp_in = 1'b0;
    lat = 0;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      if (below_pulse && lat == 0) lat = i;
    end
    check(lat == 3, "R2 latency", lat, 3);
    // R4 long low gives a single pulse only
    np = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (below_pulse) np++; end
    check(np == 0, "R4 no repeat on long low", np, 0);

    // R9 gate on clears counter
    @(negedge clk); gate_on = 1'b1;
    @(negedge clk);
    check(valley_cnt == 0, "R9 clear on gate", valley_cnt, 0);

    // R5 high during gate, then short high after release: no pulse
    cmp_in = 1'b1;
    repeat (30) @(negedge clk);
    gate_on = 1'b0;
    burst(10, 6, np, mw);
    check(np == 0, "R5 requalify after gate", np, 0);

    // R5 fall arriving with gate turning on
    for (int i = 0; i < 30; i++) begin @(negedge clk); cmp_in = 1'b1; end
    @(negedge clk); cmp_in = 1'b0; gate_on = 1'b1;
    np = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (below_pulse) np++; end
    check(np == 0, "R5 fall during gate on", np, 0);
    gate_on = 1'b0;

    // R6 enable
    en = 1'b0;
    burst(30, 6, np, mw);
    check(np == 0, "R6 disabled", np, 0);
    en = 1'b1;
    burst(30, 6, np, mw);
    check(np == 1, "R6 re-enabled", np, 1);
    check(valley_cnt == 1, "R8 step", valley_cnt, 1);

    // R8 saturation after many valleys
    for (int k = 0; k < VMAX + 3; k++) burst(QUAL, 6, np, mw);
    check(int'(valley_cnt) == VMAX, "R8 saturate", valley_cnt, VMAX);

    // R1 synchronous reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(valley_cnt == 0, "R1 reset clears", valley_cnt, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule